// File: doc/BRIEF.md
# One-Shot Match Tick Timer

This block is a 32-bit tick timer for an operating system. It sits on a simple word-wide register bus. Software loads a target value, and the timer counts one step on each cycle where the tick-enable input is high. It starts from wherever the counter currently stands and runs toward the target. If the target is not above the current position, the count wraps through the top of the 32-bit range. When the countdown runs out, the counter is pinned at the target and counting stops until software loads a new target.

A separate interrupt-enable register gates the hit. It is sampled in the cycle of the hit. When it is nonzero, a sticky status bit is set, and the level interrupt output follows that bit until software writes zero to the status register. Bus accesses are decoded from a three-bit word index. Reads return data in the same cycle, and writes take effect on the next clock edge. An access to an unmapped word, an access in the wrong direction, or a nonzero status write raises the error output for that cycle and changes no state.

Top module: `tick_match_timer`

## Requirements
- R1: After reset, the counter (word 4), status (word 5) and enable (word 7) all read zero, and irq is low.
- R2: A write to word 0 stores the target and arms a countdown. When the target is greater than the live counter, the countdown is target minus counter. The counter always reads target minus the remaining countdown, modulo 2^32.
- R3: When the target is less than or equal to the live counter, the countdown is target + (0xFFFFFFFF - counter). Right after such a write, the counter therefore reads the old counter plus one.
- R4: The countdown drops by one only on clock edges where tickEn is high. With tickEn low, the counter holds.
- R5: When the countdown reaches zero, the counter reads exactly the target. It then holds that value under further ticks until the next write to word 0.
- R6: At a hit with the enable register nonzero, status bit 0 is set and irq goes high. irq stays high as long as status bit 0 is set.
- R7: At a hit with the enable register equal to zero, neither status nor irq is set.
- R8: Writing zero to word 5 clears status and drops irq. Writing any nonzero value to word 5 is a bus error.
- R9: The following are bus errors: an access to words 1, 2, 3 or 6, a write to word 4, and a read of word 0. A bus error raises err in the same cycle, leaves all registers unchanged, and returns read data of zero.
- R10: A write to word 0 during an active countdown restarts the countdown from the live counter value.
- R11: When a hit and a status-clear write fall on the same edge, the hit wins and status stays set.
- R12: A status read returns the status bit in bit 0 with all other bits zero. A read of the enable register returns all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count strobe, high once per tick period |
| sel | input | 1 | Bus access valid this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Word index (byte address bits 4:2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the access cycle |
| err | output | 1 | Bus error for the current access |
| irq | output | 1 | Level interrupt, equal to status bit 0 |

## Verification
The countdown is tried three ways: with a target above the counter, with a target below it (the wrapped distance), and with a reload while a countdown is running. Together these separate the two distance formulas from the restart behaviour. Tick-enable is held low for a few cycles in the middle of a count, which exposes any design that counts on every clock edge. Hits are produced with the enable register both set and clear, and one hit is made to land on the same edge as a status-clear write, to fix the priority between the two. Each kind of illegal access is then followed by read-backs that confirm no state moved.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  localparam logic [IDX_W-1:0] IDX_TARGET = 3'd0;
  localparam logic [IDX_W-1:0] IDX_COUNT  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_STATUS = 3'd5;
  localparam logic [IDX_W-1:0] IDX_ENABLE = 3'd7;

  typedef struct packed {
    logic loadTarget;
    logic countTick;
  } tmt_strobe_t;
endpackage

// File: rtl/tmt_datapath.sv
module tmt_datapath
  import tmt_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmt_strobe_t  strobes,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] countVal,
  output logic         hit
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] targetReg;
  logic [W-1:0] remain;
  logic         running;
  logic [W-1:0] distance;

  assign countVal = targetReg - remain;

  always_comb begin
    if (wdata > countVal) distance = wdata - countVal;
    else                  distance = wdata + (ALL_ONES - countVal);
  end

  assign hit = running && strobes.countTick && !strobes.loadTarget && (remain <= ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetReg <= '0;
      remain    <= '0;
      running   <= 1'b0;
    end else if (strobes.loadTarget) begin
      targetReg <= wdata;
      remain    <= distance;
      running   <= 1'b1;
    end else if (hit) begin
      remain    <= '0;
      running   <= 1'b0;
    end else if (running && strobes.countTick) begin
      remain    <= remain - ONE;
    end
  end

  // R5: counter snaps to the target on a hit and the engine stops
  assert_snap_R5: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (countVal == $past(targetReg)) && !running);

  // R5: idle engine holds its value without a reload
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strobes.loadTarget) |=> $stable(countVal));

  // R4: no movement on edges without a tick
  assert_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (running && !strobes.countTick && !strobes.loadTarget) |=> $stable(countVal));

  // R10: a reload always leaves the engine running
  assert_rearm_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTarget |=> running);
endmodule

// File: rtl/tmt_ctrl.sv
module tmt_ctrl
  import tmt_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = IDX_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  countVal,
  input  logic          hit,
  output tmt_strobe_t   strobes,
  output logic [W-1:0]  rdata,
  output logic          err,
  output logic          irq
);
  logic         isTarget, isCount, isStatus, isEnable;
  logic         legalRead, legalWrite, wrOk, rdOk;
  logic         statusReg;
  logic [W-1:0] enableReg;

  assign isTarget = (addr == IDX_TARGET);
  assign isCount  = (addr == IDX_COUNT);
  assign isStatus = (addr == IDX_STATUS);
  assign isEnable = (addr == IDX_ENABLE);

  assign legalRead  = isCount || isStatus || isEnable;
  assign legalWrite = isTarget || isEnable || (isStatus && (wdata == '0));

  assign err  = sel && (wr ? !legalWrite : !legalRead);
  assign wrOk = sel && wr && !err;
  assign rdOk = sel && !wr && !err;

  assign strobes.loadTarget = wrOk && isTarget;
  assign strobes.countTick  = tickEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= 1'b0;
      enableReg <= '0;
    end else begin
      if (hit && (enableReg != '0)) statusReg <= 1'b1;
      else if (wrOk && isStatus)    statusReg <= 1'b0;
      if (wrOk && isEnable)         enableReg <= wdata;
    end
  end

  assign irq = statusReg;

  always_comb begin
    rdata = '0;
    if (rdOk) begin
      if (isCount)       rdata = countVal;
      else if (isStatus) rdata = {{(W-1){1'b0}}, statusReg};
      else if (isEnable) rdata = enableReg;
    end
  end

  // R6: enabled hit raises the interrupt on the next cycle
  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hit && (enableReg != '0)) |=> irq);

  // R7: disabled hit leaves a clear interrupt clear
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hit && (enableReg == '0) && !statusReg) |=> !irq);

  // R8: accepted clear without a hit drops the interrupt
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrOk && isStatus && !hit) |=> !irq);

  // R9: an errored access never alters the enable register
  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    err |=> (enableReg == $past(enableReg)));

  // R11: hit beats a same-edge clear
  assert_hit_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (hit && (enableReg != '0) && wrOk && isStatus) |=> irq);
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              sel,
  input  logic              wr,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              irq
);
  tmt_strobe_t       strobes;
  logic [DATA_W-1:0] countVal;
  logic              hit;

  tmt_ctrl #(.W(DATA_W), .AW(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .countVal(countVal), .hit(hit),
    .strobes(strobes), .rdata(rdata), .err(err), .irq(irq)
  );

  tmt_datapath #(.W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(wdata),
    .countVal(countVal), .hit(hit)
  );
endmodule

// File: tb/tick_match_timer_tb_top.sv
`timescale 1ns/1ps
module tick_match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  string       tagQ[$];
  logic [31:0] dataQ[$];
  logic        errQ[$];

  always #2.5 clk = ~clk;

  tick_match_timer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err), .irq(irq)
  );

  // monitor: compares each bus access against the scoreboard
  always @(negedge clk) begin
    if (sel && tagQ.size() > 0) begin
      string t;
      logic [31:0] ed;
      logic ee;
      t = tagQ.pop_front();
      ed = dataQ.pop_front();
      ee = errQ.pop_front();
      checks++;
      if (err !== ee) begin
        fails++;
        $display("FAIL %s: err actual %b expected %b", t, err, ee);
      end else if (!wr && rdata !== ed) begin
        fails++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, ed);
      end
    end
  end

  task automatic busOp(input logic w, input logic [2:0] a, input logic [31:0] d,
                       input logic [31:0] expD, input logic expE,
                       input string tag, input logic tick = 1'b0);
    sel = 1'b1; wr = w; addr = a; wdata = d; tickEn = tick;
    tagQ.push_back(tag); dataQ.push_back(expD); errQ.push_back(expE);
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0; wdata = '0; tickEn = 1'b0;
  endtask

  task automatic ticks(input int n, input logic en = 1'b1);
    tickEn = en;
    repeat (n) @(posedge clk);
    #1 tickEn = 1'b0;
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    checkIrq(1'b0, "R1 irq");
    busOp(0, 3'd4, 0, 32'd0, 0, "R1 counter");
    busOp(0, 3'd5, 0, 32'd0, 0, "R1 status");
    busOp(0, 3'd7, 0, 32'd0, 0, "R1 enable");
    // R12 enable full width
    busOp(1, 3'd7, 32'hA5A5_0001, 0, 0, "R12 enable write");
    busOp(0, 3'd7, 0, 32'hA5A5_0001, 0, "R12 enable readback");
    // R2 straight count
    busOp(1, 3'd0, 32'd20, 0, 0, "R2 target write");
    busOp(0, 3'd4, 0, 32'd0, 0, "R2 counter start");
    ticks(5);
    busOp(0, 3'd4, 0, 32'd5, 0, "R2 counter after 5");
    // R4 ticks gated
    ticks(3, 1'b0);
    busOp(0, 3'd4, 0, 32'd5, 0, "R4 hold without tick");
    ticks(14);
    busOp(0, 3'd4, 0, 32'd19, 0, "R2 one before hit");
    checkIrq(1'b0, "R6 irq before hit");
    ticks(1);
    busOp(0, 3'd4, 0, 32'd20, 0, "R5 snap to target");
    busOp(0, 3'd5, 0, 32'd1, 0, "R6 R12 status set");
    checkIrq(1'b1, "R6 irq high");
    ticks(4);
    busOp(0, 3'd4, 0, 32'd20, 0, "R5 held after hit");
    checkIrq(1'b1, "R6 irq stays");
    // R8 nonzero status write rejected
    busOp(1, 3'd5, 32'd1, 0, 1, "R8 nonzero status err");
    busOp(0, 3'd5, 0, 32'd1, 0, "R8 status kept");
    busOp(1, 3'd5, 32'd0, 0, 0, "R8 clear");
    checkIrq(1'b0, "R8 irq dropped");
    busOp(0, 3'd5, 0, 32'd0, 0, "R8 status cleared");
    // R3 wrapped distance: 10 + (FFFFFFFF - 20), reads 21
    busOp(1, 3'd0, 32'd10, 0, 0, "R3 wrap target");
    busOp(0, 3'd4, 0, 32'd21, 0, "R3 wrap counter");
    // R10 restart mid-run from live counter 21
    busOp(1, 3'd0, 32'd30, 0, 0, "R10 reload");
    busOp(0, 3'd4, 0, 32'd21, 0, "R10 counter kept");
    ticks(8);
    busOp(0, 3'd4, 0, 32'd29, 0, "R10 near hit");
    ticks(1);
    busOp(0, 3'd4, 0, 32'd30, 0, "R10 hit at new target");
    checkIrq(1'b1, "R6 second hit");
    busOp(1, 3'd5, 32'd0, 0, 0, "R8 clear again");
    // R7 disabled hit
    busOp(1, 3'd7, 32'd0, 0, 0, "R7 disable");
    busOp(1, 3'd0, 32'd33, 0, 0, "R7 target");
    ticks(3);
    busOp(0, 3'd4, 0, 32'd33, 0, "R7 counter snapped");
    busOp(0, 3'd5, 0, 32'd0, 0, "R7 status clear");
    checkIrq(1'b0, "R7 irq low");
    // R9 bus errors leave state alone
    busOp(1, 3'd4, 32'd99, 0, 1, "R9 write counter");
    busOp(0, 3'd4, 0, 32'd33, 0, "R9 counter unchanged");
    busOp(0, 3'd0, 0, 32'd0, 1, "R9 read target");
    busOp(0, 3'd1, 0, 32'd0, 1, "R9 read unmapped");
    busOp(1, 3'd3, 32'd1, 0, 1, "R9 write unmapped");
    busOp(1, 3'd6, 32'd1, 0, 1, "R9 write word6");
    busOp(0, 3'd7, 0, 32'd0, 0, "R9 enable unchanged");
    busOp(0, 3'd4, 0, 32'd33, 0, "R9 counter still");
    // R11 hit and clear on the same edge
    busOp(1, 3'd7, 32'd1, 0, 0, "R11 enable");
    busOp(1, 3'd0, 32'd35, 0, 0, "R11 target a");
    ticks(2);
    checkIrq(1'b1, "R11 status set");
    busOp(1, 3'd0, 32'd37, 0, 0, "R11 target b");
    ticks(1);
    busOp(1, 3'd5, 32'd0, 0, 0, "R11 clear with hit", 1'b1);
    busOp(0, 3'd5, 0, 32'd1, 0, "R11 hit wins");
    checkIrq(1'b1, "R11 irq held");
    busOp(0, 3'd4, 0, 32'd37, 0, "R11 counter");
    busOp(1, 3'd5, 32'd0, 0, 0, "R8 final clear");
    checkIrq(1'b0, "R8 final irq");
    @(posedge clk); #1;
    finishRun();
  end
endmodule